// File: doc/BRIEF.md
# USB Power-Switch Control and Over-Current Interrupt

This block holds the control state of a USB power switch. That state covers suspend, the master or slave role, and a 100 mA or 500 mA current limit for each role. From the role it picks which current limit is active. It also watches two comparator flags from the analog current sensor, one for each trip level. A rising edge on the flag that matches the active limit sets a sticky over-current status bit. That status bit, unless masked, drives the first-level USB interrupt line.

Software reaches the block through a small register port. Writes take effect on the next clock edge, and read data arrives one cycle after the read strobe. Three event inputs put control bits back to their default values without any software action:

- an undervoltage pulse,
- a boot-failure pulse,
- a master-to-slave pulse from the external role state machine.

Top module: `usbsw_ctrl`

## Requirements
- R1: After reset, all control bits, the mask bit, the status bit, `rdata`, the switch outputs and `usb_irq` are 0.
- R2: Address 0 holds the control field: bit 0 suspend, bit 1 role (1 = master), bit 2 master-mode limit, bit 3 slave-mode limit, where a limit bit of 1 means 500 mA. A write stores bits 3:0, a read returns them, and `sw_suspend`/`sw_master` follow bits 0 and 1.
- R3: An `uvlo_evt` or `bootfail_evt` pulse clears the suspend and slave-limit bits and leaves the role and master-limit bits unchanged. If the pulse falls in the same cycle as a write, the pulse wins.
- R4: A `role_drop_evt` pulse clears the role bit.
- R5: `sw_lim500` equals the master-limit bit in master role and the slave-limit bit in slave role.
- R6: When the active limit is 500 mA, only `oc_500` can trip; otherwise only `oc_100` can. Only a rising edge sets the status bit, so a flag that stays high does not set it again after it is cleared.
- R7: While suspend is 1, no comparator flag sets the status bit.
- R8: The status bit is bit 0 of address 1. A read there returns its value and clears it.
- R9: If a rising edge and a status read fall in the same cycle, the read returns the old value and the bit ends up set.
- R10: The mask is bit 0 of address 2. `usb_irq` is 1 exactly when status is 1 and the mask is 0. `usb_irq` rises in the same cycle the status sets, and it rises one cycle after a write that clears the mask.
- R11: `usb_irq` falls in the same cycle that a read clears the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |
| uvlo_evt | input | 1 | Line undervoltage event pulse |
| bootfail_evt | input | 1 | Boot failure event pulse |
| role_drop_evt | input | 1 | Master-to-slave role change pulse |
| oc_100 | input | 1 | Comparator flag, 100 mA level exceeded |
| oc_500 | input | 1 | Comparator flag, 500 mA level exceeded |
| sw_suspend | output | 1 | Opens the switch when 1 |
| sw_master | output | 1 | Current role, 1 = master |
| sw_lim500 | output | 1 | Active limit, 1 = 500 mA |
| usb_irq | output | 1 | First-level USB interrupt |

## Verification
The assertions check several rules on every cycle:

- the interrupt never stands without a status bit, and never while the mask was set;
- a newly set status bit never follows a suspended cycle;
- the event pulses always leave their bits cleared one edge later;
- the active-limit output always agrees with the stored role and limit bits;
- a status read that meets a fresh edge never clears the bit.

Only the bench scenarios can show the rest: the register layout and read-back values, which flag trips under each role and limit, that a flag held high trips only once, and how the interrupt follows a mask change.

// File: rtl/usbsw_pkg.sv
package usbsw_pkg;
  // Control field, bit 0 is suspend.
  typedef struct packed {
    logic lim_s;
    logic lim_m;
    logic master;
    logic suspend;
  } ctrl_t;

  localparam int CTRL_W    = $bits(ctrl_t);
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STS  = 1;
  localparam int ADDR_MASK = 2;
endpackage

// File: rtl/usbsw_regs.sv
module usbsw_regs
  import usbsw_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              uvlo_evt,
  input  logic              bootfail_evt,
  input  logic              role_drop_evt,
  output ctrl_t             ctrl_q,
  output logic              mask_q,
  output logic              lim_sel_q
);
  ctrl_t ctrl_d;
  logic  wr_ctrl, wr_mask;
  logic  unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DATA_W-1:CTRL_W];
  assign wr_ctrl = wr_en && (addr == ADDR_W'(ADDR_CTRL));
  assign wr_mask = wr_en && (addr == ADDR_W'(ADDR_MASK));

  // Events override a write landing in the same cycle.
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    if (uvlo_evt || bootfail_evt) begin
      ctrl_d.suspend = 1'b0;
      ctrl_d.lim_s   = 1'b0;
    end
    if (role_drop_evt) ctrl_d.master = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      mask_q    <= 1'b0;
      lim_sel_q <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      lim_sel_q <= ctrl_d.master ? ctrl_d.lim_m : ctrl_d.lim_s;
      if (wr_mask) mask_q <= wdata[0];
    end
  end

  assert_event_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (uvlo_evt || bootfail_evt) |=> (!ctrl_q.suspend && !ctrl_q.lim_s));

  assert_role_drop_R4: assert property (@(posedge clk) disable iff (rst)
    role_drop_evt |=> !ctrl_q.master);

  assert_limit_select_R5: assert property (@(posedge clk) disable iff (rst)
    lim_sel_q == (ctrl_q.master ? ctrl_q.lim_m : ctrl_q.lim_s));
endmodule

// File: rtl/usbsw_ocp.sv
module usbsw_ocp (
  input  logic clk,
  input  logic rst,
  input  logic suspend,
  input  logic lim_sel,
  input  logic oc_100,
  input  logic oc_500,
  input  logic rd_clr,
  input  logic mask,
  output logic sts_q,
  output logic irq_q
);
  logic eff_oc, eff_d, rise, sts_nxt;

  // An open switch cannot report over-current.
  assign eff_oc  = !suspend && (lim_sel ? oc_500 : oc_100);
  assign rise    = eff_oc && !eff_d;
  assign sts_nxt = rise || (sts_q && !rd_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_d <= 1'b0;
      sts_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      eff_d <= eff_oc;
      sts_q <= sts_nxt;
      irq_q <= sts_nxt && !mask;
    end
  end

  assert_irq_needs_status_R11: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> sts_q);

  assert_irq_unmasked_R10: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> !$past(mask));

  assert_suspend_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_q) |-> !$past(suspend));

  assert_trip_flag_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_q) |-> $past(lim_sel ? oc_500 : oc_100));

  assert_edge_beats_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rise && rd_clr) |=> sts_q);
endmodule

// File: rtl/usbsw_ctrl.sv
module usbsw_ctrl
  import usbsw_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              uvlo_evt,
  input  logic              bootfail_evt,
  input  logic              role_drop_evt,
  input  logic              oc_100,
  input  logic              oc_500,
  output logic              sw_suspend,
  output logic              sw_master,
  output logic              sw_lim500,
  output logic              usb_irq
);
  ctrl_t ctrl_q;
  logic  mask_q, lim_sel_q, sts_q, rd_clr;

  assign rd_clr = rd_en && (addr == ADDR_W'(ADDR_STS));

  usbsw_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .uvlo_evt(uvlo_evt), .bootfail_evt(bootfail_evt),
    .role_drop_evt(role_drop_evt),
    .ctrl_q(ctrl_q), .mask_q(mask_q), .lim_sel_q(lim_sel_q)
  );

  usbsw_ocp u_ocp (
    .clk(clk), .rst(rst), .suspend(ctrl_q.suspend), .lim_sel(lim_sel_q),
    .oc_100(oc_100), .oc_500(oc_500), .rd_clr(rd_clr), .mask(mask_q),
    .sts_q(sts_q), .irq_q(usb_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        ADDR_W'(ADDR_CTRL): rdata <= DATA_W'(ctrl_q);
        ADDR_W'(ADDR_STS):  rdata <= DATA_W'(sts_q);
        ADDR_W'(ADDR_MASK): rdata <= DATA_W'(mask_q);
        default:            rdata <= '0;
      endcase
    end
  end

  assign sw_suspend = ctrl_q.suspend;
  assign sw_master  = ctrl_q.master;
  assign sw_lim500  = lim_sel_q;
endmodule

// File: tb/usbsw_ctrl_bench.sv
`timescale 1ns/1ps
module usbsw_ctrl_bench;
  logic       clk = 1'b0, rst = 1'b1;
  logic       wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       uvlo_evt = 0, bootfail_evt = 0, role_drop_evt = 0;
  logic       oc_100 = 0, oc_500 = 0;
  logic       sw_suspend, sw_master, sw_lim500, usb_irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 0;

  always #2.5 clk = ~clk;

  usbsw_ctrl u_usbsw_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .uvlo_evt(uvlo_evt),
    .bootfail_evt(bootfail_evt), .role_drop_evt(role_drop_evt),
    .oc_100(oc_100), .oc_500(oc_500), .sw_suspend(sw_suspend),
    .sw_master(sw_master), .sw_lim500(sw_lim500), .usb_irq(usb_irq)
  );

  // Monitor: compare read data one cycle after each read strobe.
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] e, string req);
    exp_q.push_back(e); tag_q.push_back(req);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3); rst = 0; idle(1);
    // R1 reset state
    chk("R1 suspend", sw_suspend, 0); chk("R1 master", sw_master, 0);
    chk("R1 lim", sw_lim500, 0);      chk("R1 irq", usb_irq, 0);
    rd(0, 8'h00, "R1 ctrl"); rd(1, 8'h00, "R1 status"); rd(2, 8'h00, "R1 mask");

    // R2/R5 slave with 500 mA limit
    wr(0, 8'h08);
    chk("R5 slave 500", sw_lim500, 1);
    rd(0, 8'h08, "R2 readback");

    // R6 wrong-level flag does not trip
    oc_100 = 1; idle(2); oc_100 = 0; idle(1);
    rd(1, 8'h00, "R6 oc_100 ignored at 500mA");

    // R6/R10 rising edge sets status and irq in the same cycle
    oc_500 = 1; idle(1);
    chk("R10 irq on set", usb_irq, 1);
    rd(1, 8'h01, "R8 status read");
    chk("R11 irq falls on clear", usb_irq, 0);
    idle(2);
    rd(1, 8'h00, "R6 held flag no retrigger");
    oc_500 = 0; idle(1);

    // R9 edge and read in the same cycle
    oc_500 = 1;
    rd(1, 8'h00, "R9 read returns old");
    rd(1, 8'h01, "R9 bit stays set");
    oc_500 = 0; idle(1);

    // R10 mask
    wr(2, 8'h01);
    rd(2, 8'h01, "R10 mask readback");
    oc_500 = 1; idle(1); oc_500 = 0;
    chk("R10 masked irq", usb_irq, 0);
    wr(2, 8'h00);
    chk("R10 irq one cycle after unmask", usb_irq, 0);
    idle(1);
    chk("R10 irq after unmask", usb_irq, 1);
    rd(1, 8'h01, "R10 status while masked");
    chk("R11 irq cleared", usb_irq, 0);

    // R7 suspend blocks tripping
    wr(0, 8'h09);
    chk("R2 suspend out", sw_suspend, 1);
    oc_500 = 1; idle(2); oc_500 = 0; idle(1);
    rd(1, 8'h00, "R7 no trip while suspended");

    // R3 undervoltage and boot-fail
    wr(0, 8'h0F);
    chk("R2 master out", sw_master, 1);
    uvlo_evt = 1; idle(1); uvlo_evt = 0;
    rd(0, 8'h06, "R3 uvlo clears");
    bootfail_evt = 1; wr(0, 8'h0F); bootfail_evt = 0;
    rd(0, 8'h06, "R3 bootfail beats write");

    // R4 role drop
    role_drop_evt = 1; idle(1); role_drop_evt = 0;
    rd(0, 8'h04, "R4 role cleared");
    chk("R4 master out", sw_master, 0);
    chk("R5 slave 100", sw_lim500, 0);

    // R5 master mode selects master limit
    wr(0, 8'h06);
    chk("R5 master 500", sw_lim500, 1);
    wr(0, 8'h0A);
    chk("R5 master 100", sw_lim500, 0);

    // R6 master at 100 mA
    oc_500 = 1; idle(1); oc_500 = 0; idle(1);
    rd(1, 8'h00, "R6 oc_500 ignored at 100mA");
    oc_100 = 1; idle(1); oc_100 = 0; idle(1);
    rd(1, 8'h01, "R6 oc_100 trips at 100mA");

    idle(2);
    finish_run();
  end
endmodule